// File: doc/BRIEF.md
# Oversampled Serial Receiver with Held-Word Overflow Policy

This block turns an asynchronous NRZ serial line into received words. A separate enable input supplies the oversampling tick, normally sixteen per bit time. The line is first corrected for polarity and synchronised. A start bit is accepted only if it is confirmed at its middle. Each later bit is sampled at its midpoint, least significant bit first. The format selector picks the frame shape: 7-bit data, 8-bit data, 8-bit data with an odd or even parity bit, or 8-bit data with a ninth address-marker bit. Every finished word carries its data byte, its address marker, a parity-error flag and a framing-error flag.

Received words are queued in a two-entry FIFO. Behind the FIFO, the deserialiser's own register can hold one more finished word, which gives three stages of storage in all. If a word finishes while all three stages are full, a sticky overflow flag is raised and the word is lost. While that flag is set, every further word is dropped. The flag can be cleared on its own, by a flush that empties every stage, or by turning the block off. A policy input decides what the deserialiser does while the flag is set. It can keep following frame boundaries, so that the first frame in flight after the clear is kept. Or it can stop hunting for start bits until the clear.

The consumer reads the head word on the read outputs and advances the queue with a one-cycle pop pulse.

Top module: `uart_rx_ovf`

## Requirements
- R1: The head word stays on the read outputs until a pop. Words leave in arrival order. A pop while the queue is empty has no effect.
- R2: `rsr_held` is 1 exactly when three words are waiting. The third word moves into the FIFO after the next pop, and `rsr_held` then returns to 0.
- R3: If a word finishes while three words are waiting and no pop occurs in that cycle, `ovf` is set and the stored words are left unchanged.
- R4: `ovf` is sticky. Words that finish while it is set are discarded. A pulse on `ovf_clear` clears only the flag, and later words are stored again.
- R5: A `flush` pulse, or `enable` held low, empties all three stages and clears `ovf`. While `enable` is low the line is ignored.
- R6: With `run_ovf`=1 the deserialiser keeps following frames during an overflow, so a frame already in flight when the overflow is cleared is stored. With `run_ovf`=0 it does not start on any start bit while `ovf` is set, so that frame is never delivered.
- R7: `mode` encoding: 0 is 8 data bits; 1 is 7 data bits, with `rd_data[7]` reading 0; 2 is 8 bits plus odd parity; 3 is 8 bits plus even parity; 4 is 8 bits plus an address bit; 5 to 7 act as 0. Data arrives LSB first, and the ninth bit, when present, follows bit 7.
- R8: In mode 3, `rd_perr`=1 when the count of ones over the eight data bits and the ninth bit is odd. In mode 2, `rd_perr`=1 when that count is even. In every other mode `rd_perr`=0.
- R9: In mode 4, `rd_addr` equals the received ninth bit. In every other mode it is 0.
- R10: A stop bit sampled as 0 sets `rd_ferr` on that word, and the word is still stored with its data.
- R11: A low pulse shorter than half a bit time is a false start. No word results, and the receiver returns to waiting for a start bit.
- R12: With `rx_invert`=1 the line is inverted before any other processing, so the idle level is low and a high level is a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Block on; low clears all storage and the flag |
| os_tick | input | 1 | Oversampling enable, OSR pulses per bit time |
| mode | input | 3 | Frame format selector (see R7) |
| rx_invert | input | 1 | Invert the serial line |
| run_ovf | input | 1 | Keep following frames during overflow |
| rx_line | input | 1 | Serial input |
| rd_pop | input | 1 | Remove the head word |
| flush | input | 1 | Empty all stages and clear overflow |
| ovf_clear | input | 1 | Clear the overflow flag |
| rd_valid | output | 1 | A head word is present |
| rd_data | output | 8 | Head word data |
| rd_addr | output | 1 | Head word address marker |
| rd_perr | output | 1 | Head word parity error |
| rd_ferr | output | 1 | Head word framing error |
| rsr_held | output | 1 | Third word is waiting in the deserialiser |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The properties assume that a finished word never arrives in two consecutive cycles. This holds because a frame takes many oversampling ticks. They also assume that `mode` is not changed while words are being judged. The bench changes `mode`, `rx_invert` and `run_ovf` only while the line is idle and the queue is empty. It drives each bit for exactly OSR ticks, and it reads the outputs only after the stop bit and some idle time have passed. Flush and clear pulses last one cycle and are placed at known bit positions within a frame. This lets the two overflow policies be told apart by whether the frame in flight is delivered.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Frame format codes seen on the mode input
  typedef enum logic [2:0] {
    FMT_8N    = 3'd0,
    FMT_7N    = 3'd1,
    FMT_8ODD  = 3'd2,
    FMT_8EVEN = 3'd3,
    FMT_9ADR  = 3'd4
  } rx_fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_NINTH = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  // One received word with its per-word status
  typedef struct packed {
    logic [7:0] data;
    logic       addr;
    logic       perr;
    logic       ferr;
  } rx_word_t;

endpackage

// File: rtl/uart_rx_rstsync.sv
module uart_rx_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/uart_rx_linein.sv
module uart_rx_linein #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic rx_invert,
  output logic bit_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  // Polarity is corrected ahead of the synchroniser so the reset value
  // (idle high) is correct for both polarities.
  always_comb sync_d[0] = rx_line ^ rx_invert;

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_comb sync_d[g] = sync_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign bit_o = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       bit_i,
  input  logic [2:0] mode,
  input  logic       halt,
  output logic       frm_valid,
  output rx_word_t   frm
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] os_q, os_d;
  logic [2:0]       idx_q, idx_d;
  logic [7:0]       shreg_q, shreg_d;
  logic             ninth_q, ninth_d;
  logic             valid_q, valid_d;
  rx_word_t         frm_q, frm_d;
  logic             frm_load;
  logic             adv;

  logic       has_ninth;
  logic [2:0] last_idx;
  logic       ones_odd;

  always_comb begin
    has_ninth = (mode == FMT_8ODD) || (mode == FMT_8EVEN) || (mode == FMT_9ADR);
    last_idx  = (mode == FMT_7N) ? 3'd6 : 3'd7;
    ones_odd  = (^shreg_q) ^ ninth_q;
  end

  assign adv = tick | clr;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    os_d     = os_q;
    idx_d    = idx_q;
    shreg_d  = shreg_q;
    ninth_d  = ninth_q;
    valid_d  = 1'b0;
    frm_load = 1'b0;
    frm_d    = frm_q;
    if (clr) begin
      state_d = ST_IDLE;
      os_d    = '0;
      idx_d   = '0;
    end else if (tick) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!halt && !bit_i) begin
            state_d = ST_START;
            os_d    = '0;
          end
        end
        ST_START: begin
          if (os_q == MID_CNT) begin
            os_d    = '0;
            idx_d   = '0;
            shreg_d = '0;
            ninth_d = 1'b0;
            state_d = bit_i ? ST_IDLE : ST_DATA;
          end else begin
            os_d = os_q + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (os_q == LAST_CNT) begin
            os_d           = '0;
            shreg_d[idx_q] = bit_i;
            idx_d          = idx_q + 3'd1;
            if (idx_q == last_idx) state_d = has_ninth ? ST_NINTH : ST_STOP;
          end else begin
            os_d = os_q + CNT_W'(1);
          end
        end
        ST_NINTH: begin
          if (os_q == LAST_CNT) begin
            os_d    = '0;
            ninth_d = bit_i;
            state_d = ST_STOP;
          end else begin
            os_d = os_q + CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (os_q == LAST_CNT) begin
            os_d       = '0;
            state_d    = ST_IDLE;
            valid_d    = 1'b1;
            frm_load   = 1'b1;
            frm_d.data = shreg_q;
            frm_d.addr = (mode == FMT_9ADR) ? ninth_q : 1'b0;
            frm_d.perr = (mode == FMT_8EVEN) ? ones_odd :
                         (mode == FMT_8ODD)  ? ~ones_odd : 1'b0;
            frm_d.ferr = ~bit_i;
          end else begin
            os_d = os_q + CNT_W'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      ninth_q <= 1'b0;
    end else if (adv) begin
      state_q <= state_d;
      os_q    <= os_d;
      idx_q   <= idx_d;
      shreg_q <= shreg_d;
      ninth_q <= ninth_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frm_q <= '0;
    else if (frm_load) frm_q <= frm_d;
  end

  assign frm_valid = valid_q;
  assign frm       = frm_q;
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     flush,
  input  logic     push,
  input  rx_word_t push_word,
  input  logic     pop,
  input  logic     ovf_clear,
  output rx_word_t head,
  output logic     head_valid,
  output logic     tail_held,
  output logic     ovf
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  rx_word_t         slot_q [DEPTH];
  rx_word_t         slot_d [DEPTH];
  logic [DEPTH-1:0] slot_en;
  logic [CNT_W-1:0] cnt_q, cnt_d, wr_idx;
  logic             ovf_q, ovf_d;
  logic             wipe, pop_ok, room, push_ok, ovf_set;

  always_comb begin
    wipe    = clr | flush;
    pop_ok  = pop && (cnt_q != '0);
    room    = (cnt_q != FULL_CNT) || pop_ok;
    push_ok = push && !ovf_q && room;
    ovf_set = push && !ovf_q && !room;
    wr_idx  = pop_ok ? (cnt_q - CNT_W'(1)) : cnt_q;
  end

  always_comb begin
    if (wipe) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      cnt_d = cnt_q;
      if (push_ok && !pop_ok)      cnt_d = cnt_q + CNT_W'(1);
      else if (pop_ok && !push_ok) cnt_d = cnt_q - CNT_W'(1);
      ovf_d = (ovf_q & ~ovf_clear) | ovf_set;
    end
  end

  // Slot i takes slot i+1 on a pop; the write slot takes the new word.
  always_comb begin
    int src;
    for (int i = 0; i < DEPTH; i++) begin
      src        = (i < DEPTH - 1) ? i + 1 : i;
      slot_d[i]  = pop_ok ? slot_q[src] : slot_q[i];
      slot_en[i] = !wipe && pop_ok;
      if (!wipe && push_ok && (CNT_W'(i) == wr_idx)) begin
        slot_d[i]  = push_word;
        slot_en[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (slot_en[i]) slot_q[i] <= slot_d[i];
      end
    end
  end

  assign head       = slot_q[0];
  assign head_valid = (cnt_q != '0);
  assign tail_held  = (cnt_q == FULL_CNT);
  assign ovf        = ovf_q;
endmodule

// File: rtl/uart_rx_ovf.sv
module uart_rx_ovf
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_DEPTH  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       os_tick,
  input  logic [2:0] mode,
  input  logic       rx_invert,
  input  logic       run_ovf,
  input  logic       rx_line,
  input  logic       rd_pop,
  input  logic       flush,
  input  logic       ovf_clear,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_addr,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rsr_held,
  output logic       ovf
);
  // The deserialiser's register is the last storage stage behind the FIFO
  localparam int STORE_DEPTH = FIFO_DEPTH + 1;

  logic     rst_int_n;
  logic     rx_bit;
  logic     frm_valid;
  rx_word_t frm;
  rx_word_t head;
  logic     ovf_int;
  logic     halt;

  assign halt = ovf_int & ~run_ovf;

  uart_rx_rstsync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  uart_rx_linein #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rx_line   (rx_line),
    .rx_invert (rx_invert),
    .bit_o     (rx_bit)
  );

  uart_rx_framer #(.OSR(OSR)) u_framer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (~enable),
    .tick      (os_tick),
    .bit_i     (rx_bit),
    .mode      (mode),
    .halt      (halt),
    .frm_valid (frm_valid),
    .frm       (frm)
  );

  uart_rx_store #(.DEPTH(STORE_DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (~enable),
    .flush      (flush),
    .push       (frm_valid),
    .push_word  (frm),
    .pop        (rd_pop),
    .ovf_clear  (ovf_clear),
    .head       (head),
    .head_valid (rd_valid),
    .tail_held  (rsr_held),
    .ovf        (ovf_int)
  );

  assign rd_data = head.data;
  assign rd_addr = head.addr;
  assign rd_perr = head.perr;
  assign rd_ferr = head.ferr;
  assign ovf     = ovf_int;
endmodule

// File: rtl/uart_rx_ovf_chk.sv
module uart_rx_ovf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       os_tick,
  input logic [2:0] mode,
  input logic       rx_invert,
  input logic       run_ovf,
  input logic       rx_line,
  input logic       rd_pop,
  input logic       flush,
  input logic       ovf_clear,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       rd_addr,
  input logic       rd_perr,
  input logic       rd_ferr,
  input logic       rsr_held,
  input logic       ovf
);
  // R1: head word stays put until popped
  p_head_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_pop && !flush && enable |=> rd_valid && $stable(rd_data));

  // R2: a held third word implies a present head
  p_held_has_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsr_held |-> rd_valid);

  // R3: overflow only rises from the full state without a pop
  p_ovf_from_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(rsr_held && !rd_pop));

  // R4: flag is sticky until a clear action
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clear && !flush && enable |=> ovf);

  // R4: clear pulse drops the flag
  p_ovf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && ovf_clear |=> !ovf);

  // R5: flush or disable empties everything
  p_flush_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || !enable) |=> !rd_valid && !ovf && !rsr_held);
endmodule

bind uart_rx_ovf uart_rx_ovf_chk u_chk (.*);

// File: tb/uart_rx_ovf_bench.sv
module uart_rx_ovf_bench;
  localparam int TICK_DIV = 4;
  localparam int OSR      = 16;
  localparam int BIT_CLKS = TICK_DIV * OSR;
  localparam int NVEC     = 12;

  // {mode[3], invert, bad_stop, sent[9], exp_data[8], exp_addr, exp_perr, exp_ferr}
  localparam logic [24:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 1'b0, 9'h0A5, 8'hA5, 3'b000},   // R7 8-bit
    {3'd1, 1'b0, 1'b0, 9'h02A, 8'h2A, 3'b000},   // R7 7-bit
    {3'd3, 1'b0, 1'b0, 9'h003, 8'h03, 3'b000},   // R8 even ok
    {3'd3, 1'b0, 1'b0, 9'h007, 8'h07, 3'b010},   // R8 even bad
    {3'd2, 1'b0, 1'b0, 9'h007, 8'h07, 3'b000},   // R8 odd ok
    {3'd2, 1'b0, 1'b0, 9'h003, 8'h03, 3'b010},   // R8 odd bad
    {3'd4, 1'b0, 1'b0, 9'h13C, 8'h3C, 3'b100},   // R9 address
    {3'd4, 1'b0, 1'b0, 9'h081, 8'h81, 3'b000},   // R9 data
    {3'd0, 1'b0, 1'b1, 9'h05A, 8'h5A, 3'b001},   // R10 framing
    {3'd0, 1'b1, 1'b0, 9'h0C3, 8'hC3, 3'b000},   // R12 inverted
    {3'd1, 1'b0, 1'b0, 9'h0FF, 8'h7F, 3'b000},   // R7 bit7 zero
    {3'd3, 1'b0, 1'b0, 9'h101, 8'h01, 3'b000}    // R8 ninth set
  };

  logic       clk;
  logic       rst_n;
  logic       enable;
  logic       os_tick;
  logic [2:0] mode;
  logic       rx_invert;
  logic       run_ovf;
  logic       rx_line;
  logic       rd_pop;
  logic       flush;
  logic       ovf_clear;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_addr;
  logic       rd_perr;
  logic       rd_ferr;
  logic       rsr_held;
  logic       ovf;

  int checks;
  int fails;
  logic done;

  uart_rx_ovf u_uart_rx_ovf (
    .clk(clk), .rst_n(rst_n), .enable(enable), .os_tick(os_tick),
    .mode(mode), .rx_invert(rx_invert), .run_ovf(run_ovf), .rx_line(rx_line),
    .rd_pop(rd_pop), .flush(flush), .ovf_clear(ovf_clear),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_addr(rd_addr),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rsr_held(rsr_held), .ovf(ovf)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial begin
    os_tick = 1'b0;
    forever begin
      for (int k = 0; k < TICK_DIV; k++) begin
        @(negedge clk);
        os_tick = (k == TICK_DIV - 1);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b, input logic fl);
    rx_line = b ^ rx_invert;
    if (fl) begin
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      repeat (BIT_CLKS - 1) @(negedge clk);
    end else begin
      repeat (BIT_CLKS) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input logic bad, input int flush_bit);
    int nd;
    logic has9;
    nd   = (mode == 3'd1) ? 7 : 8;
    has9 = (mode == 3'd2) || (mode == 3'd3) || (mode == 3'd4);
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < nd; i++) drive_bit(d[i], i == flush_bit);
    if (has9) drive_bit(d[8], 1'b0);
    drive_bit(~bad, 1'b0);
    drive_bit(1'b1, 1'b0);
    drive_bit(1'b1, 1'b0);
  endtask

  task automatic send8(input logic [7:0] d);
    send_frame({1'b0, d}, 1'b0, -1);
  endtask

  task automatic pulse_pop();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    ovf_clear = 1'b1;
    @(negedge clk);
    ovf_clear = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; enable = 1'b1; mode = 3'd0; rx_invert = 1'b0; run_ovf = 1'b1;
    rx_line = 1'b1; rd_pop = 1'b0; flush = 1'b0; ovf_clear = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Reset state
    chk("R1 reset rd_valid", rd_valid, 0);
    chk("R3 reset ovf", ovf, 0);
    chk("R2 reset rsr_held", rsr_held, 0);

    // Format table
    for (int v = 0; v < NVEC; v++) begin
      mode      = VEC[v][24:22];
      rx_invert = VEC[v][21];
      rx_line   = ~VEC[v][21];
      repeat (BIT_CLKS) @(negedge clk);
      send_frame(VEC[v][19:11], VEC[v][20], -1);
      chk("R7 vec valid", rd_valid, 1);
      chk("R7 R12 vec data", rd_data, VEC[v][10:3]);
      chk("R9 vec addr", rd_addr, VEC[v][2]);
      chk("R8 vec perr", rd_perr, VEC[v][1]);
      chk("R10 vec ferr", rd_ferr, VEC[v][0]);
      pulse_pop();
      chk("R1 vec emptied", rd_valid, 0);
    end
    mode = 3'd0; rx_invert = 1'b0; rx_line = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);

    // R11 false start
    rx_line = 1'b0;
    repeat (BIT_CLKS / 4) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk("R11 glitch no word", rd_valid, 0);
    send8(8'h5C);
    chk("R11 next word", rd_data, 8'h5C);
    pulse_pop();

    // R1 pop on empty ignored
    pulse_pop();
    chk("R1 empty pop", rd_valid, 0);
    send8(8'h99);
    chk("R1 after empty pop", rd_data, 8'h99);
    pulse_pop();

    // R2 / R3 / R4 fill and overflow
    send8(8'h11);
    send8(8'h22);
    chk("R2 two waiting", rsr_held, 0);
    send8(8'h33);
    chk("R2 third held", rsr_held, 1);
    chk("R3 no ovf yet", ovf, 0);
    send8(8'h44);
    chk("R3 ovf set", ovf, 1);
    chk("R3 head kept", rd_data, 8'h11);
    pulse_pop();
    chk("R2 third moved", rsr_held, 0);
    chk("R4 ovf sticky", ovf, 1);
    chk("R1 order", rd_data, 8'h22);
    send8(8'h55);
    chk("R4 dropped while set", rsr_held, 0);
    pulse_clear();
    chk("R4 flag cleared", ovf, 0);
    chk("R4 data kept", rd_data, 8'h22);
    send8(8'h66);
    chk("R4 stores again", rsr_held, 1);
    pulse_pop();
    chk("R1 order 33", rd_data, 8'h33);
    pulse_pop();
    chk("R1 order 66", rd_data, 8'h66);
    pulse_pop();
    chk("R1 drained", rd_valid, 0);

    // R5 flush
    send8(8'h01); send8(8'h02); send8(8'h03); send8(8'h04);
    chk("R5 pre ovf", ovf, 1);
    pulse_flush();
    chk("R5 flush valid", rd_valid, 0);
    chk("R5 flush ovf", ovf, 0);
    chk("R5 flush held", rsr_held, 0);
    send8(8'hA1);
    chk("R5 after flush", rd_data, 8'hA1);
    pulse_pop();

    // R6 run during overflow
    run_ovf = 1'b1;
    send8(8'h01); send8(8'h02); send8(8'h03); send8(8'h04);
    send_frame(9'h0F0, 1'b0, 5);
    chk("R6 run kept valid", rd_valid, 1);
    chk("R6 run kept data", rd_data, 8'hF0);
    pulse_pop();
    run_ovf = 1'b0;
    send8(8'h01); send8(8'h02); send8(8'h03); send8(8'h04);
    send_frame(9'h0F0, 1'b0, 5);
    chk("R6 halt lost frame", rd_valid, 0);
    send8(8'h3E);
    chk("R6 halt resumes", rd_data, 8'h3E);
    pulse_pop();
    run_ovf = 1'b1;

    // R5 enable low
    send8(8'h77);
    enable = 1'b0;
    @(negedge clk);
    chk("R5 disable clears", rd_valid, 0);
    send8(8'h12);
    enable = 1'b1;
    @(negedge clk);
    chk("R5 disabled ignores line", rd_valid, 0);
    send8(8'h34);
    chk("R5 re-enabled", rd_data, 8'h34);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule